// File: doc/BRIEF.md
# Eight-Pin I/O Port with Peripheral Direction Override

This block controls an eight-pin general-purpose I/O port through a small register bus. Software sets each pin's output level, chooses whether each pin is an input or an output, and can ask for reduced drive strength on output pins. An SPI block and a set of serial channels can take pins away from software. The SPI block takes over both the direction and the output level of the pins in its mask. An enabled serial transmit channel forces its pin to drive. An enabled serial receive channel forces its pin to listen. When the peripheral lets go, the software direction bit is obeyed again.

Pad levels come back through a two-flop synchronizer. Software has two read views of them. The pin-input view always shows the synchronized pin level. The data view shows the stored output value on driven pins and the synchronized level on listening pins. Because of the synchronizer, a level change at the pad reaches the read views two clock cycles later.

Top module: `gpio_port`

## Requirements
- R1: After a synchronous active-low reset, the data, direction and drive registers read 0 and every pin is an input (`pad_oe` = 0).
- R2: Under register control, direction bit 1 makes the pin an output and bit 0 makes it an input. `pad_do` carries the data register bit for every pin under register control.
- R3: While `spi_en` is 1, each pin in the SPI mask (default pins 2 to 5, mask 0x3C) takes its direction from `spi_oe` and its output level from `spi_do`. The direction register has no effect on those pins.
- R4: Serial channel k transmits on pin 2k+1. While `sci_tx_en[k]` is 1, that pin is an output that drives `sci_tx_do[k]`, whatever its direction bit holds.
- R5: Serial channel k receives on pin 2k. While `sci_rx_en[k]` is 1, that pin is an input, whatever its direction bit holds.
- R6: When the peripheral enables drop to 0, every pin follows the direction register again.
- R7: The priority is fixed: SPI override first, then serial transmit or receive forcing, then the direction register.
- R8: The pin-input register (address 1) returns the pad level as it was two rising clock edges earlier. After one edge it still shows the old level.
- R9: The data register (address 0) reads back the stored data bit on pins that are currently outputs and the synchronized pad level on pins that are inputs.
- R10: `pad_rdrv` is the drive register bit (address 3; 1 means reduced drive) ANDed with the effective output enable. It is 0 on input pins.
- R11: The data (address 0), direction (address 2) and drive (address 3) registers can be written at any time and read back at any time. A write to address 1 changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 2 | Register select: 0 data, 1 pin input, 2 direction, 3 drive |
| bus_we | input | 1 | Write strobe, sampled on the rising edge |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr`, combinational |
| spi_en | input | 1 | SPI takes over the pins in its mask |
| spi_oe | input | 8 | Per-pin direction wanted by the SPI block |
| spi_do | input | 8 | Per-pin output level from the SPI block |
| sci_tx_en | input | 2 | Transmit enable of each serial channel |
| sci_rx_en | input | 2 | Receive enable of each serial channel |
| sci_tx_do | input | 2 | Transmit level of each serial channel |
| pad_di | input | 8 | Raw pad input levels |
| pad_oe | output | 8 | Effective per-pin output enable |
| pad_do | output | 8 | Effective per-pin output level |
| pad_rdrv | output | 8 | Per-pin reduced-drive select |

## Verification
The direction resolver is exercised with several patterns. Register control alone, with mixed direction bits, confirms that each pin follows its own bit. SPI enabled with the direction register all ones shows that masked pins ignore it while unmasked pins do not. A transmit enable over an all-zero direction and a receive enable over an all-ones direction show that each forcing acts against the register value. A pattern with SPI and a transmit channel both claiming pin 3 separates the priority order from a simple OR of the sources. The read path uses a mixed-direction pattern, so a swap of the data and pin views becomes visible. A timed pad change shows the difference between one and two synchronizer stages.

// File: rtl/gpio_pkg.sv
// Package gpio_pkg
// Shared register address encoding for the I/O port.
// Assumes a two-bit register address space with every address used.
package gpio_pkg;
    localparam int ADDR_W = 2;

    typedef enum logic [ADDR_W-1:0] {
        REG_DATA = 2'd0,
        REG_PIN  = 2'd1,
        REG_DIR  = 2'd2,
        REG_DRV  = 2'd3
    } reg_sel_e;
endpackage

// File: rtl/gpio_in_sync.sv
// Module gpio_in_sync
// Two-flop synchronizer for the raw pad levels.
// Assumes the pads are asynchronous to clk. The output lags the input by two edges.
module gpio_in_sync #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta_q;
    logic [W-1:0] sync_q;
    logic [1:0]   age_q;

    // Shift the pad levels through two stages.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= '0;
            sync_q <= '0;
        end else begin
            meta_q <= d;
            sync_q <= meta_q;
        end
    end

    // Count edges since reset, saturating at 2, so the latency check can start.
    always_ff @(posedge clk) begin
        if (!rst_n) age_q <= '0;
        else if (age_q != 2'd2) age_q <= age_q + 2'd1;
    end

    assign q = sync_q;

    // R8
    sync_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (age_q == 2'd2) |-> (q == $past(d, 2)));
endmodule

// File: rtl/gpio_dir_resolve.sv
// Module gpio_dir_resolve
// Works out the effective direction and output level of each pin.
// The sources are the SPI override, serial channel forcing and the registers.
// Assumes serial channel k transmits on pin 2k+1 and receives on pin 2k.
module gpio_dir_resolve #(
    parameter int           W            = 8,
    parameter int           NUM_SCI      = 2,
    parameter logic [W-1:0] SPI_PIN_MASK = 8'h3C
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [W-1:0]       ddr,
    input  logic [W-1:0]       dat,
    input  logic               spi_en,
    input  logic [W-1:0]       spi_oe,
    input  logic [W-1:0]       spi_do,
    input  logic [NUM_SCI-1:0] sci_tx_en,
    input  logic [NUM_SCI-1:0] sci_rx_en,
    input  logic [NUM_SCI-1:0] sci_tx_do,
    output logic [W-1:0]       eff_oe,
    output logic [W-1:0]       eff_do
);
    logic [W-1:0] spi_own;
    logic [W-1:0] tx_own;
    logic [W-1:0] rx_own;

    assign spi_own = spi_en ? SPI_PIN_MASK : '0;

    for (genvar i = 0; i < W; i++) begin : g_pin
        logic tx_hit;
        logic tx_val;
        logic rx_hit;

        // Find whether an enabled serial channel claims this pin.
        always_comb begin
            tx_hit = 1'b0;
            tx_val = 1'b0;
            rx_hit = 1'b0;
            for (int k = 0; k < NUM_SCI; k++) begin
                if ((2*k + 1 == i) && sci_tx_en[k]) begin
                    tx_hit = 1'b1;
                    tx_val = sci_tx_do[k];
                end
                if ((2*k == i) && sci_rx_en[k]) rx_hit = 1'b1;
            end
        end

        assign tx_own[i] = tx_hit;
        assign rx_own[i] = rx_hit;

        // Fixed priority: SPI first, then serial forcing, then the registers.
        always_comb begin
            if (spi_own[i]) begin
                eff_oe[i] = spi_oe[i];
                eff_do[i] = spi_do[i];
            end else if (tx_hit) begin
                eff_oe[i] = 1'b1;
                eff_do[i] = tx_val;
            end else if (rx_hit) begin
                eff_oe[i] = 1'b0;
                eff_do[i] = dat[i];
            end else begin
                eff_oe[i] = ddr[i];
                eff_do[i] = dat[i];
            end
        end
    end

    // R3
    spi_owns_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((eff_oe & spi_own) == (spi_oe & spi_own)));
    // R4
    tx_forces_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((eff_oe & tx_own & ~spi_own) == (tx_own & ~spi_own)));
    // R5
    rx_forces_in_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((eff_oe & rx_own & ~spi_own) == '0));
    // R2
    reg_ctrl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((eff_oe & ~(spi_own | tx_own | rx_own)) == (ddr & ~(spi_own | tx_own | rx_own))));
endmodule

// File: rtl/gpio_regs.sv
// Module gpio_regs
// Holds the data, direction and drive registers and decodes the bus.
// Assumes single-cycle writes and a combinational read. Address 1 is read-only.
module gpio_regs
    import gpio_pkg::*;
#(
    parameter int W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              we,
    input  logic [W-1:0]      wdata,
    input  logic [W-1:0]      eff_oe,
    input  logic [W-1:0]      pin_sync,
    output logic [W-1:0]      rdata,
    output logic [W-1:0]      dat_q,
    output logic [W-1:0]      ddr_q,
    output logic [W-1:0]      rdr_q
);
    reg_sel_e sel;
    assign sel = reg_sel_e'(addr);

    // Update the writable registers on a bus write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dat_q <= '0;
            ddr_q <= '0;
            rdr_q <= '0;
        end else if (we) begin
            case (sel)
                REG_DATA: dat_q <= wdata;
                REG_DIR:  ddr_q <= wdata;
                REG_DRV:  rdr_q <= wdata;
                default:  ;
            endcase
        end
    end

    // Select the read view for the addressed register.
    always_comb begin
        case (sel)
            REG_DATA: rdata = (dat_q & eff_oe) | (pin_sync & ~eff_oe);
            REG_PIN:  rdata = pin_sync;
            REG_DIR:  rdata = ddr_q;
            REG_DRV:  rdata = rdr_q;
            default:  rdata = '0;
        endcase
    end

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |=> (dat_q == '0 && ddr_q == '0 && rdr_q == '0));
    // R11
    dir_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (we && addr == 2'd2) |=> (ddr_q == $past(wdata)));
    // R11
    pin_write_inert_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (we && addr == 2'd1) |=> ($stable(dat_q) && $stable(ddr_q) && $stable(rdr_q)));
endmodule

// File: rtl/gpio_port.sv
// Module gpio_port
// Top of the eight-pin I/O port. It joins the registers, the direction resolver
// and the input synchronizer, and drives the pad controls.
// Assumes the peripheral enables are synchronous to clk.
module gpio_port
    import gpio_pkg::*;
#(
    parameter int           W            = 8,
    parameter int           NUM_SCI      = 2,
    parameter logic [W-1:0] SPI_PIN_MASK = 8'h3C
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic               bus_we,
    input  logic [W-1:0]       bus_wdata,
    output logic [W-1:0]       bus_rdata,
    input  logic               spi_en,
    input  logic [W-1:0]       spi_oe,
    input  logic [W-1:0]       spi_do,
    input  logic [NUM_SCI-1:0] sci_tx_en,
    input  logic [NUM_SCI-1:0] sci_rx_en,
    input  logic [NUM_SCI-1:0] sci_tx_do,
    input  logic [W-1:0]       pad_di,
    output logic [W-1:0]       pad_oe,
    output logic [W-1:0]       pad_do,
    output logic [W-1:0]       pad_rdrv
);
    logic [W-1:0] dat_q, ddr_q, rdr_q, pin_sync, eff_oe, eff_do;

    gpio_regs #(.W(W)) u_regs (
        .clk(clk), .rst_n(rst_n), .addr(bus_addr), .we(bus_we), .wdata(bus_wdata),
        .eff_oe(eff_oe), .pin_sync(pin_sync), .rdata(bus_rdata),
        .dat_q(dat_q), .ddr_q(ddr_q), .rdr_q(rdr_q)
    );

    gpio_dir_resolve #(.W(W), .NUM_SCI(NUM_SCI), .SPI_PIN_MASK(SPI_PIN_MASK)) u_resolve (
        .clk(clk), .rst_n(rst_n), .ddr(ddr_q), .dat(dat_q),
        .spi_en(spi_en), .spi_oe(spi_oe), .spi_do(spi_do),
        .sci_tx_en(sci_tx_en), .sci_rx_en(sci_rx_en), .sci_tx_do(sci_tx_do),
        .eff_oe(eff_oe), .eff_do(eff_do)
    );

    gpio_in_sync #(.W(W)) u_sync (
        .clk(clk), .rst_n(rst_n), .d(pad_di), .q(pin_sync)
    );

    assign pad_oe   = eff_oe;
    assign pad_do   = eff_do;
    assign pad_rdrv = rdr_q & eff_oe;

    // R10
    rdrv_input_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((pad_rdrv & ~pad_oe) == '0));
endmodule

// File: tb/gpio_port_bench.sv
module gpio_port_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] bus_addr = '0;
    logic       bus_we = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       spi_en = 1'b0;
    logic [7:0] spi_oe = '0;
    logic [7:0] spi_do = '0;
    logic [1:0] sci_tx_en = '0;
    logic [1:0] sci_rx_en = '0;
    logic [1:0] sci_tx_do = '0;
    logic [7:0] pad_di = '0;
    logic [7:0] pad_oe, pad_do, pad_rdrv;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    gpio_port u_gpio_port (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .spi_en(spi_en),
        .spi_oe(spi_oe), .spi_do(spi_do), .sci_tx_en(sci_tx_en),
        .sci_rx_en(sci_rx_en), .sci_tx_do(sci_tx_do), .pad_di(pad_di),
        .pad_oe(pad_oe), .pad_do(pad_do), .pad_rdrv(pad_rdrv)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
        #1;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic t_reset();
        logic [7:0] v;
        rd(2'd2, v); chk("R1 dir after reset", v, 8'h00);
        rd(2'd3, v); chk("R1 drive after reset", v, 8'h00);
        rd(2'd0, v); chk("R1 data after reset", v, 8'h00);
        chk("R1 pad_oe after reset", pad_oe, 8'h00);
    endtask

    task automatic t_reg_ctrl();
        wr(2'd0, 8'hA5);
        wr(2'd2, 8'hF0);
        chk("R2 oe follows dir", pad_oe, 8'hF0);
        chk("R2 do follows data", pad_do, 8'hA5);
    endtask

    task automatic t_spi();
        wr(2'd2, 8'hFF);
        spi_en = 1'b1; spi_oe = 8'h0C; spi_do = 8'h34;
        #1;
        chk("R3 spi oe override", pad_oe, 8'hCF);
        chk("R3 spi do override", pad_do, 8'hB5);
        spi_en = 1'b0; spi_oe = '0; spi_do = '0;
    endtask

    task automatic t_sci();
        wr(2'd2, 8'h00);
        sci_tx_en = 2'b01; sci_tx_do = 2'b01;
        #1;
        chk("R4 tx forces output", pad_oe, 8'h02);
        chk("R4 tx level", pad_do, 8'hA7);
        sci_tx_en = '0; sci_tx_do = '0;
        wr(2'd2, 8'hFF);
        sci_rx_en = 2'b10;
        #1;
        chk("R5 rx forces input", pad_oe, 8'hFB);
    endtask

    task automatic t_prio();
        sci_rx_en = '0;
        wr(2'd2, 8'h00);
        spi_en = 1'b1; spi_oe = 8'h00;
        sci_tx_en = 2'b11; sci_tx_do = 2'b11;
        #1;
        chk("R7 spi beats tx on pin 3", pad_oe, 8'h02);
        spi_en = 1'b0; sci_tx_en = '0; sci_tx_do = '0;
    endtask

    task automatic t_release();
        spi_en = 1'b1; sci_tx_en = 2'b01; sci_rx_en = 2'b10;
        wr(2'd2, 8'h5A);
        spi_en = 1'b0; sci_tx_en = '0; sci_rx_en = '0;
        #1;
        chk("R6 dir regains control", pad_oe, 8'h5A);
    endtask

    task automatic t_sync();
        logic [7:0] v;
        wr(2'd2, 8'h00);
        @(negedge clk);
        pad_di = 8'h3C;
        bus_addr = 2'd1;
        #1;
        chk("R8 no edge yet", bus_rdata, 8'h00);
        rd(2'd1, v); chk("R8 one edge still old", v, 8'h00);
        rd(2'd1, v); chk("R8 two edges new level", v, 8'h3C);
    endtask

    task automatic t_data_read();
        logic [7:0] v;
        wr(2'd2, 8'h0F);
        rd(2'd0, v); chk("R9 mixed data view", v, 8'h35);
        rd(2'd1, v); chk("R9 pin view", v, 8'h3C);
    endtask

    task automatic t_drive();
        logic [7:0] v;
        wr(2'd3, 8'hFF);
        chk("R10 reduced drive only on outputs", pad_rdrv, 8'h0F);
        rd(2'd3, v); chk("R10 drive readback", v, 8'hFF);
    endtask

    task automatic t_pin_write();
        logic [7:0] v;
        wr(2'd1, 8'h77);
        rd(2'd1, v); chk("R11 pin reg not writable", v, 8'h3C);
        rd(2'd0, v); chk("R11 data unchanged", v, 8'h35);
        rd(2'd2, v); chk("R11 dir readback", v, 8'h0F);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_reg_ctrl();
        t_spi();
        t_sci();
        t_prio();
        t_release();
        t_sync();
        t_data_read();
        t_drive();
        t_pin_write();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule